// File: doc/BRIEF.md
# LCD Video Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal and vertical sync, a data-enable strobe, and the column and row coordinates of the pixel being shown. The pixel rate is a clock-enable pulse taken from the source clock. It either divides the source clock by a programmable ratio or runs at the full source rate. Every timing field uses a count-minus-one encoding. A line runs in this order: sync, back porch, active pixels, front porch. A frame runs in the same order, counted in lines.

Timing fields and the divider are copied into shadow registers only when a frame starts. Software can therefore rewrite them at any time without tearing the picture. When the enable is set while idle, scanning starts on the next clock. When the enable is cleared, the current frame finishes and the block then stops. A frame event sets a pending flag, which is cleared by a one-cycle clear pulse. The event is either the start of vertical sync or the start of the first active line. The interrupt output is that flag gated by an interrupt enable.

Top module: `lcd_timing_gen`

## Requirements
- R1: A line lasts (cfg_hsw+1)+(cfg_hbp+1)+(cfg_hact+1)+(cfg_hfp+1) pixels. Sync is active for the first cfg_hsw+1 pixels, and active video starts after cfg_hsw+cfg_hbp+2 pixels.
- R2: A frame lasts (cfg_vsw+1)+(cfg_vbp+1)+(cfg_vact+1)+(cfg_vfp+1) lines. Vertical sync covers the first cfg_vsw+1 whole lines, and active lines start at line cfg_vsw+cfg_vbp+2. The next frame follows with no gap.
- R3: de is high only on the cfg_hact+1 active pixels of each of the cfg_vact+1 active lines. px_x and px_y read 0 at the first active pixel and count up by one per pixel and per line.
- R4: A polarity bit of 1 makes the sync output high while the sync is active. A bit of 0 makes it low. Polarity is not shadowed.
- R5: With cfg_div_sel=1, pix_ce pulses once every cfg_div+1 source clocks, and every pixel lasts that many clocks. With cfg_div_sel=0, pix_ce is high on every clock.
- R6: Timing fields and divider settings are sampled only when a frame starts. A change made mid-frame leaves the current frame unchanged and applies from the next frame.
- R7: Setting cfg_en while idle raises running on the next clock. The first pixel is then line 0, pixel 0, with both syncs active.
- R8: Clearing cfg_en mid-frame lets the frame complete. running falls after the last pixel, and afterwards de is low and both syncs are inactive.
- R9: With irq_frame_en=1, irq_pending is set by the selected event: irq_src=0 selects the first pixel of a frame, and irq_src=1 selects the first pixel of the first active line. With irq_frame_en=0 it is never set. irq is irq_pending AND irq_en.
- R10: A one-cycle pulse on irq_clr clears irq_pending. When a set event falls in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Scan enable; a clear takes effect at end of frame |
| cfg_hsw | input | HW | Hsync width minus one |
| cfg_hbp | input | HW | Horizontal back porch minus one |
| cfg_hact | input | HW | Active pixels per line minus one |
| cfg_hfp | input | HW | Horizontal front porch minus one |
| cfg_vsw | input | VW | Vsync width in lines minus one |
| cfg_vbp | input | VW | Vertical back porch minus one |
| cfg_vact | input | VW | Active lines minus one |
| cfg_vfp | input | VW | Vertical front porch minus one |
| cfg_div_sel | input | 1 | 1 = divided pixel rate, 0 = 1:1 |
| cfg_div | input | DW | Divide ratio minus one |
| cfg_hs_pol | input | 1 | Hsync active level |
| cfg_vs_pol | input | 1 | Vsync active level |
| irq_en | input | 1 | Interrupt output enable |
| irq_frame_en | input | 1 | Frame event enable |
| irq_src | input | 1 | Event select: 0 vsync start, 1 first active line |
| irq_clr | input | 1 | Clear pulse for irq_pending |
| running | output | 1 | Scanning in progress |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | HW | Active column |
| px_y | output | VW | Active row |
| irq_pending | output | 1 | Frame event pending flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are those that depend on a single cycle within a long frame. One is a clear pulse landing exactly on the cycle of the set event. Another is a timing rewrite or an enable clear arriving mid-frame. The stimulus reaches them by counting cycles from the known frame start and driving the clear, the rewrite or the disable at a computed index. Its frame-measuring task is run over random timing, divider and polarity settings, so that the shadow load and the divided pixel phase are crossed with many frame shapes.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
   typedef enum logic {
      EVT_VSYNC_START  = 1'b0,
      EVT_ACTIVE_START = 1'b1
   } evt_sel_e;
endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic [W-1:0] sw,
   input  logic [W-1:0] bp,
   input  logic [W-1:0] act,
   input  logic [W-1:0] fp,
   output logic         last,
   output logic         zero,
   output logic         at_astart,
   output logic         sync_on,
   output logic         act_on,
   output logic [W-1:0] pos
);
   localparam int CW = W + 2;

   logic [CW-1:0] cnt, tot_m1, a_lo, a_hi;

   assign tot_m1    = CW'(sw) + CW'(bp) + CW'(act) + CW'(fp) + CW'(3);
   assign a_lo      = CW'(sw) + CW'(bp) + CW'(2);
   assign a_hi      = a_lo + CW'(act);
   assign last      = (cnt == tot_m1);
   assign zero      = (cnt == '0);
   assign at_astart = (cnt == a_lo);
   assign sync_on   = (cnt <= CW'(sw));
   assign act_on    = (cnt >= a_lo) && (cnt <= a_hi);
   assign pos       = W'(cnt - a_lo);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= last ? '0 : cnt + CW'(1);
   end
endmodule

// File: rtl/lcd_tg_pixce.sv
module lcd_tg_pixce #(
   parameter int DW      = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          sel,
   input  logic [DW-1:0] div,
   output logic          ce
);
   generate
      if (HAS_DIV) begin : g_div
         logic [DW-1:0] pc;
         assign ce = !sel || (pc >= div);
         always_ff @(posedge clk) begin
            if (!rst_n)             pc <= '0;
            else if (restart || ce) pc <= '0;
            else                    pc <= pc + DW'(1);
         end
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = ^{clk, rst_n, restart, sel, div};
         assign ce = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lcd_tg_irq.sv
module lcd_tg_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic frame_en,
   input  logic en,
   input  logic clr,
   output logic pending,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)               pending <= 1'b0;
      else if (frame_en && evt) pending <= 1'b1;
      else if (clr)             pending <= 1'b0;
   end
   assign irq = pending & en;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_tg_pkg::*;
#(
   parameter int HW      = 12,
   parameter int VW      = 11,
   parameter int DW      = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_en,
   input  logic [HW-1:0] cfg_hsw,
   input  logic [HW-1:0] cfg_hbp,
   input  logic [HW-1:0] cfg_hact,
   input  logic [HW-1:0] cfg_hfp,
   input  logic [VW-1:0] cfg_vsw,
   input  logic [VW-1:0] cfg_vbp,
   input  logic [VW-1:0] cfg_vact,
   input  logic [VW-1:0] cfg_vfp,
   input  logic          cfg_div_sel,
   input  logic [DW-1:0] cfg_div,
   input  logic          cfg_hs_pol,
   input  logic          cfg_vs_pol,
   input  logic          irq_en,
   input  logic          irq_frame_en,
   input  logic          irq_src,
   input  logic          irq_clr,
   output logic          running,
   output logic          pix_ce,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [HW-1:0] px_x,
   output logic [VW-1:0] px_y,
   output logic          irq_pending,
   output logic          irq
);
   generate
      if (HW < 2 || VW < 2 || DW < 1) begin : g_bad_params
         $error("lcd_timing_gen: HW and VW must be at least 2, DW at least 1");
      end
   endgenerate

   // shadow copies, loaded only when a frame starts
   logic [HW-1:0] sh_hsw, sh_hbp, sh_hact, sh_hfp;
   logic [VW-1:0] sh_vsw, sh_vbp, sh_vact, sh_vfp;
   logic [DW-1:0] sh_div;
   logic          sh_sel;

   logic h_last, h_zero, h_ast, h_sync, h_act;
   logic v_last, v_zero, v_ast, v_sync, v_act;
   logic [HW-1:0] h_pos;
   logic [VW-1:0] v_pos;
   logic frame_end, load, hstep, vstep, evt;
   evt_sel_e evt_sel;

   assign hstep     = pix_ce & running;
   assign vstep     = hstep & h_last;
   assign frame_end = vstep & v_last;
   assign load      = cfg_en & (!running | frame_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         sh_hsw <= '0; sh_hbp <= '0; sh_hact <= '0; sh_hfp <= '0;
         sh_vsw <= '0; sh_vbp <= '0; sh_vact <= '0; sh_vfp <= '0;
         sh_div <= '0; sh_sel <= 1'b0;
      end else begin
         if (load) begin
            sh_hsw <= cfg_hsw; sh_hbp <= cfg_hbp; sh_hact <= cfg_hact; sh_hfp <= cfg_hfp;
            sh_vsw <= cfg_vsw; sh_vbp <= cfg_vbp; sh_vact <= cfg_vact; sh_vfp <= cfg_vfp;
            sh_div <= cfg_div; sh_sel <= cfg_div_sel;
         end
         if (!running || frame_end) running <= cfg_en;
      end
   end

   lcd_tg_pixce #(.DW(DW), .HAS_DIV(HAS_DIV)) u_pixce (
      .clk(clk), .rst_n(rst_n), .restart(!running && cfg_en),
      .sel(sh_sel), .div(sh_div), .ce(pix_ce)
   );

   lcd_tg_axis #(.W(HW)) u_hax (
      .clk(clk), .rst_n(rst_n), .step(hstep),
      .sw(sh_hsw), .bp(sh_hbp), .act(sh_hact), .fp(sh_hfp),
      .last(h_last), .zero(h_zero), .at_astart(h_ast),
      .sync_on(h_sync), .act_on(h_act), .pos(h_pos)
   );

   lcd_tg_axis #(.W(VW)) u_vax (
      .clk(clk), .rst_n(rst_n), .step(vstep),
      .sw(sh_vsw), .bp(sh_vbp), .act(sh_vact), .fp(sh_vfp),
      .last(v_last), .zero(v_zero), .at_astart(v_ast),
      .sync_on(v_sync), .act_on(v_act), .pos(v_pos)
   );

   logic unused_hast;
   assign unused_hast = h_ast;

   assign hsync = cfg_hs_pol ? (running & h_sync) : !(running & h_sync);
   assign vsync = cfg_vs_pol ? (running & v_sync) : !(running & v_sync);
   assign de    = running & h_act & v_act;
   assign px_x  = de ? h_pos : '0;
   assign px_y  = de ? v_pos : '0;

   assign evt_sel = evt_sel_e'(irq_src);
   assign evt = hstep & h_zero & ((evt_sel == EVT_ACTIVE_START) ? v_ast : v_zero);

   lcd_tg_irq u_irq (
      .clk(clk), .rst_n(rst_n), .evt(evt), .frame_en(irq_frame_en),
      .en(irq_en), .clr(irq_clr), .pending(irq_pending), .irq(irq)
   );
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
   parameter int HW = 12,
   parameter int VW = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic          running,
   input logic          pix_ce,
   input logic          hsync,
   input logic          vsync,
   input logic          de,
   input logic [HW-1:0] px_x,
   input logic [VW-1:0] px_y,
   input logic          cfg_hs_pol,
   input logic          cfg_vs_pol,
   input logic          irq_clr,
   input logic          irq_frame_en,
   input logic          irq_pending
);
   assert_de_outside_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (hsync != cfg_hs_pol) && (vsync != cfg_vs_pol));

   assert_x_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (de && pix_ce) |=> (!de || px_x == $past(px_x) + HW'(1)));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!de && hsync != cfg_hs_pol && vsync != cfg_vs_pol));

   assert_hold_between_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !pix_ce) |=> ($stable(px_x) && $stable(px_y) && $stable(de)));

   assert_start_in_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> (hsync == cfg_hs_pol) && (vsync == cfg_vs_pol));

   assert_no_set_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_frame_en && !irq_pending) |=> !irq_pending);

   assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !irq_frame_en) |=> !irq_pending);
endmodule

bind lcd_timing_gen lcd_tg_chk #(.HW(HW), .VW(VW)) u_chk (
   .clk(clk), .rst_n(rst_n), .running(running), .pix_ce(pix_ce),
   .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y),
   .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol), .irq_clr(irq_clr),
   .irq_frame_en(irq_frame_en), .irq_pending(irq_pending)
);

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
   localparam int HW = 12, VW = 11, DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b0;
   logic [HW-1:0] cfg_hsw = '0, cfg_hbp = '0, cfg_hact = '0, cfg_hfp = '0;
   logic [VW-1:0] cfg_vsw = '0, cfg_vbp = '0, cfg_vact = '0, cfg_vfp = '0;
   logic cfg_div_sel = 1'b0;
   logic [DW-1:0] cfg_div = '0;
   logic cfg_hs_pol = 1'b1, cfg_vs_pol = 1'b1;
   logic irq_en = 1'b0, irq_frame_en = 1'b0, irq_src = 1'b0, irq_clr = 1'b0;
   logic running, pix_ce, hsync, vsync, de, irq_pending, irq;
   logic [HW-1:0] px_x;
   logic [VW-1:0] px_y;

   int checks = 0, errors = 0, cycles = 0;
   int g_first_pend, g_pend_after_clr, g_irq_seen, g_run_last;

   always #4 clk = ~clk;

   lcd_timing_gen #(.HW(HW), .VW(VW), .DW(DW)) u0 (.*);

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int f_ht();
      return int'(cfg_hsw) + int'(cfg_hbp) + int'(cfg_hact) + int'(cfg_hfp) + 4;
   endfunction
   function automatic int f_vt();
      return int'(cfg_vsw) + int'(cfg_vbp) + int'(cfg_vact) + int'(cfg_vfp) + 4;
   endfunction
   function automatic int f_d();
      return cfg_div_sel ? int'(cfg_div) + 1 : 1;
   endfunction

   // Measures one frame. Caller stands just after a negedge; start=1 raises cfg_en.
   task automatic frame(input bit start, input int chg_at, input int new_hact,
                        input int stop_at, input int clr_at);
      int ht, vt, d, n, hsw, hbp, hact, vsw, vbp, vact;
      int n_de, n_hs, n_vs, n_ce, first_de, lx, ly;
      bit hp, vp;
      ht = f_ht(); vt = f_vt(); d = f_d(); n = ht * vt * d;
      hsw = cfg_hsw; hbp = cfg_hbp; hact = cfg_hact;
      vsw = cfg_vsw; vbp = cfg_vbp; vact = cfg_vact;
      hp = cfg_hs_pol; vp = cfg_vs_pol;
      n_de = 0; n_hs = 0; n_vs = 0; n_ce = 0; first_de = -1; lx = -1; ly = -1;
      g_first_pend = -1; g_pend_after_clr = -1; g_irq_seen = 0; g_run_last = 0;
      if (start) cfg_en = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         irq_clr = 1'b0;
         if (i == 0) begin
            chk("R7 running at first pixel", running, 1);
            chk("R7 vsync active at first pixel", vsync, vp);
            chk("R7 hsync active at first pixel", hsync, hp);
         end
         if (de) begin
            if (first_de < 0) begin
               first_de = i;
               chk("R3 px_x at first active pixel", px_x, 0);
               chk("R3 px_y at first active pixel", px_y, 0);
            end
            n_de++; lx = px_x; ly = px_y;
         end
         if (hsync == hp) n_hs++;
         if (vsync == vp) n_vs++;
         if (pix_ce) n_ce++;
         if (irq) g_irq_seen = 1;
         if (irq_pending && g_first_pend < 0) g_first_pend = i;
         if (i == clr_at + 1) g_pend_after_clr = irq_pending;
         if (i == n - 1) g_run_last = running;
         if (i == clr_at) irq_clr = 1'b1;
         if (i == chg_at) cfg_hact = HW'(new_hact);
         if (i == stop_at) cfg_en = 1'b0;
      end
      chk("R1 hsync active cycles per frame", n_hs, (hsw + 1) * vt * d);
      chk("R2 vsync active cycles per frame", n_vs, (vsw + 1) * ht * d);
      chk("R3 de cycles per frame", n_de, (hact + 1) * (vact + 1) * d);
      chk("R1 R2 first de cycle index", first_de, ((vsw + vbp + 2) * ht + hsw + hbp + 2) * d);
      chk("R3 px_x at last active pixel", lx, hact);
      chk("R3 px_y at last active pixel", ly, vact);
      chk("R5 pix_ce pulses per frame", n_ce, ht * vt);
   endtask

   task automatic go_idle();
      cfg_en = 1'b0;
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (!running) break;
      end
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
   endtask

   task automatic rnd_cfg();
      cfg_hsw = HW'($urandom_range(0, 3)); cfg_hbp = HW'($urandom_range(0, 3));
      cfg_hact = HW'($urandom_range(2, 9)); cfg_hfp = HW'($urandom_range(0, 3));
      cfg_vsw = VW'($urandom_range(0, 2)); cfg_vbp = VW'($urandom_range(0, 2));
      cfg_vact = VW'($urandom_range(1, 5)); cfg_vfp = VW'($urandom_range(0, 2));
      cfg_div_sel = 1'($urandom_range(0, 1)); cfg_div = DW'($urandom_range(0, 3));
      cfg_hs_pol = 1'($urandom_range(0, 1)); cfg_vs_pol = 1'($urandom_range(0, 1));
   endtask

   initial begin
      int seed, d, vstart, old_hact, n;
      seed = $urandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      chk("R8 reset running", running, 0);
      chk("R8 reset de", de, 0);
      chk("R4 reset hsync inactive high-pol", hsync, 0);
      chk("R9 reset pending", irq_pending, 0);
      chk("R9 reset irq", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed minimal frame, bypass, vsync event, later clear (R9 R10)
      irq_en = 1'b1; irq_frame_en = 1'b1; irq_src = 1'b0;
      cfg_hact = HW'(3); cfg_vact = VW'(1);
      frame(1'b1, -1, 0, -1, 5);
      chk("R9 pending set on first pixel (vsync source)", g_first_pend, 1);
      chk("R10 pending cleared by pulse", g_pend_after_clr, 0);
      chk("R9 irq seen with enable", g_irq_seen, 1);
      go_idle();

      // random frames, all shapes, divider and polarity
      for (int t = 0; t < 10; t++) begin
         rnd_cfg();
         d = f_d();
         frame(1'b1, -1, 0, -1, -10);
         chk("R9 vsync-source event index", g_first_pend, d);
         go_idle();
         chk("R4 idle hsync inactive level", hsync, !cfg_hs_pol);
      end

      // set wins over clear in the event cycle (R10)
      rnd_cfg(); cfg_div_sel = 1'b1; cfg_div = DW'(2); d = 3;
      frame(1'b1, -1, 0, -1, d - 1);
      chk("R10 set wins over simultaneous clear", g_pend_after_clr, 1);
      go_idle();

      // active-line event source (R9)
      rnd_cfg(); irq_src = 1'b1; d = f_d();
      vstart = int'(cfg_vsw) + int'(cfg_vbp) + 2;
      frame(1'b1, -1, 0, -1, -10);
      chk("R9 active-source event index", g_first_pend, vstart * f_ht() * d + d);
      go_idle();
      irq_src = 1'b0;

      // interrupt output gated off, pending still set (R9)
      rnd_cfg(); irq_en = 1'b0;
      frame(1'b1, -1, 0, -1, -10);
      chk("R9 irq low while irq_en clear", g_irq_seen, 0);
      chk("R9 pending set though output gated", g_first_pend >= 0, 1);
      go_idle();
      irq_en = 1'b1;

      // frame event disabled (R9)
      rnd_cfg(); irq_frame_en = 1'b0;
      frame(1'b1, -1, 0, -1, -10);
      chk("R9 no pending with frame event off", g_first_pend, -1);
      go_idle();
      irq_frame_en = 1'b1;

      // mid-frame rewrite applies only from next frame (R6)
      rnd_cfg(); cfg_hact = HW'(4); old_hact = 4;
      n = f_ht() * f_vt() * f_d();
      frame(1'b1, n / 2, 7, -1, -10);
      chk("R6 hact held in current frame", old_hact, 4);
      frame(1'b0, -1, 0, -1, -10);
      go_idle();

      // stop mid-frame finishes the frame (R8)
      rnd_cfg();
      n = f_ht() * f_vt() * f_d();
      frame(1'b1, -1, 0, n / 2, -10);
      chk("R8 running through last pixel", g_run_last, 1);
      @(negedge clk);
      chk("R8 stopped after frame", running, 0);
      chk("R8 de low after stop", de, 0);
      chk("R8 hsync inactive after stop", hsync, !cfg_hs_pol);
      chk("R8 vsync inactive after stop", vsync, !cfg_vs_pol);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule